// File: doc/BRIEF.md
# Allocation Grant Comparator for a Virtual-Channel Router

This block watches one router's allocators from the side. In every cycle it looks at the grant made to each input virtual channel by the VC allocator, at the grant made to each input port by the switch allocator, and at which output virtual channels already belong to a packet in flight. It flags the grant patterns that would mix flits from two packets or lose flits. These patterns are two inputs sharing one output VC, a grant to an output VC that is already reserved, a grant to an index that does not exist, more than one grant bit for a single requester, and two input ports sharing one output port. The decision is made by combinational logic in the cycle the grants appear.

When a violation is seen, the block registers the grant vectors of that cycle. In the next cycle it issues them back as an invalidate command, together with a strobe that tells the crossbar outputs to drop the flits they are passing. A sticky fault flag stays set until the router reports that recovery is finished. The router uses this flag to stay in its degraded mode. Some grants are wrong but harmless: an unreserved VC granted to the wrong input, or a request that is never served. The block does not flag these, because network-level recovery deals with them.

Grant encodings are as follows. Input VC `i = port*NVC + vc` owns bits `[i*GW +: GW]` of the VC grant bus, where `GW` is the number of output VCs rounded up to a power of two. Bit `o` set in that slice means output VC `o = port*NVC + vc`. Input port `p` owns bits `[p*NPORT +: NPORT]` of the switch grant bus, and bit `q` in that slice means output port `q`. An all-zero slice means no grant.

Top module: `vc_alloc_guard`

## Requirements
- R1: `fault_now` is combinational: it rises in the same cycle as the offending grant inputs, with no register between them.
- R2: Two or more input VC slices with the same output VC bit set in one cycle raise `fault_now`.
- R3: A grant to output VC `o` while `ovc_rsv[o]` is 1 raises `fault_now`.
- R4: A VC grant slice with a bit set at an index of `NPORT*NVC` or above, or with more than one bit set, raises `fault_now`.
- R5: A switch grant slice with more than one bit set, or two input ports granted the same output port, raises `fault_now`.
- R6: `fault_now` stays 0 for legal grants. This includes a grant of any unreserved output VC to any single input VC, and reserved output VCs that nobody is granted.
- R7: In the cycle after `fault_now` was 1, `inval` is 1, and `kill_va` and `kill_sa` equal the grant buses of the faulting cycle. In the cycle after `fault_now` was 0, `inval` is 0 and `kill_va` and `kill_sa` are all zero.
- R8: `xbar_discard` is 1 exactly in the cycles where the previous cycle had `fault_now` set.
- R9: `fault_latched` is set by any fault and stays set until a cycle with `recov_done` high and no new fault clears it. A new fault in the same cycle as `recov_done` keeps it set.
- R10: While `rst_n` is low, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| va_gnt | input | NPORT*NVC*GW | VC allocator grant per input VC, one slice each |
| sa_gnt | input | NPORT*NPORT | Switch allocator grant per input port, one slice each |
| ovc_rsv | input | NPORT*NVC | Output VC already reserved, sampled before this cycle's grants |
| recov_done | input | 1 | Recovery finished; clears the sticky fault |
| fault_now | output | 1 | Illegal grant pattern in the current cycle |
| inval | output | 1 | Invalidate the previous cycle's grants |
| kill_va | output | NPORT*NVC*GW | VC grants to be withdrawn |
| kill_sa | output | NPORT*NPORT | Switch grants to be withdrawn |
| xbar_discard | output | 1 | Drop flits at the crossbar outputs this cycle |
| fault_latched | output | 1 | Sticky fault for degraded mode |

## Verification
The properties assume that `ovc_rsv` shows reservations made in earlier cycles and does not already include the grants of the current cycle. If it did, every legal grant would count as a grant to a reserved VC. The bench keeps to this assumption by setting reservation bits only on VCs that it never grants in the same step, except in the one scenario that tests that conflict on purpose. Each scenario drives grant patterns for a single cycle and then returns every input to zero, so each invalidate pulse can be traced to one known set of grants.

// File: rtl/vc_alloc_guard.sv
module vc_alloc_guard #(
  parameter int NPORT = 5,
  parameter int NVC   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NPORT*NVC*(1<<$clog2(NPORT*NVC))-1:0] va_gnt,
  input  logic [NPORT*NPORT-1:0]          sa_gnt,
  input  logic [NPORT*NVC-1:0]            ovc_rsv,
  input  logic                            recov_done,
  output logic                            fault_now,
  output logic                            inval,
  output logic [NPORT*NVC*(1<<$clog2(NPORT*NVC))-1:0] kill_va,
  output logic [NPORT*NPORT-1:0]          kill_sa,
  output logic                            xbar_discard,
  output logic                            fault_latched
);
  localparam int NOVC = NPORT * NVC;
  localparam int GW   = 1 << $clog2(NOVC);
  localparam logic [GW-1:0] OKMASK = {GW{1'b1}} >> (GW - NOVC);

  logic [NOVC-1:0]  vseen, vdup;
  logic [NPORT-1:0] sseen, sdup;
  logic             vbad, sbad;

  always_comb begin
    vseen = '0;
    vdup  = '0;
    vbad  = 1'b0;
    for (int i = 0; i < NOVC; i++) begin
      if ($countones(va_gnt[i*GW +: GW]) > 1) vbad = 1'b1;
      if (|(va_gnt[i*GW +: GW] & ~OKMASK)) vbad = 1'b1;
      vdup  = vdup | (vseen & va_gnt[i*GW +: NOVC]);
      vseen = vseen | va_gnt[i*GW +: NOVC];
    end
  end

  always_comb begin
    sseen = '0;
    sdup  = '0;
    sbad  = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if ($countones(sa_gnt[p*NPORT +: NPORT]) > 1) sbad = 1'b1;
      sdup  = sdup | (sseen & sa_gnt[p*NPORT +: NPORT]);
      sseen = sseen | sa_gnt[p*NPORT +: NPORT];
    end
  end

  assign fault_now = vbad | (|vdup) | (|(vseen & ovc_rsv)) | sbad | (|sdup);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inval         <= 1'b0;
      xbar_discard  <= 1'b0;
      kill_va       <= '0;
      kill_sa       <= '0;
      fault_latched <= 1'b0;
    end else begin
      inval         <= fault_now;
      xbar_discard  <= fault_now;
      kill_va       <= fault_now ? va_gnt : '0;
      kill_sa       <= fault_now ? sa_gnt : '0;
      fault_latched <= fault_now | (fault_latched & ~recov_done);
    end
  end
endmodule

// File: rtl/vc_alloc_guard_chk.sv
module vc_alloc_guard_chk #(
  parameter int NPORT = 5,
  parameter int NVC   = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NPORT*NVC*(1<<$clog2(NPORT*NVC))-1:0] va_gnt,
  input logic [NPORT*NPORT-1:0]          sa_gnt,
  input logic                            recov_done,
  input logic                            fault_now,
  input logic                            inval,
  input logic [NPORT*NVC*(1<<$clog2(NPORT*NVC))-1:0] kill_va,
  input logic [NPORT*NPORT-1:0]          kill_sa,
  input logic                            xbar_discard,
  input logic                            fault_latched
);
  // R7
  inval_follows_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> inval && kill_va == $past(va_gnt) && kill_sa == $past(sa_gnt));

  // R7
  quiet_after_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_now |=> !inval && kill_va == '0 && kill_sa == '0);

  // R8
  discard_with_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xbar_discard == inval);

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> fault_latched);

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched && !recov_done |=> fault_latched);

  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done && !fault_now |=> !fault_latched);
endmodule

bind vc_alloc_guard vc_alloc_guard_chk #(.NPORT(NPORT), .NVC(NVC)) u_chk (
  .clk(clk), .rst_n(rst_n), .va_gnt(va_gnt), .sa_gnt(sa_gnt),
  .recov_done(recov_done), .fault_now(fault_now), .inval(inval),
  .kill_va(kill_va), .kill_sa(kill_sa), .xbar_discard(xbar_discard),
  .fault_latched(fault_latched)
);

// File: tb/test_vc_alloc_guard.sv
module test_vc_alloc_guard;
  localparam int NPORT = 5;
  localparam int NVC   = 2;
  localparam int NOVC  = NPORT * NVC;
  localparam int GW    = 16;
  localparam int VW    = NOVC * GW;
  localparam int SW    = NPORT * NPORT;

  logic clk = 0, rst_n = 0, recov_done = 0;
  logic [VW-1:0]   va_gnt = '0;
  logic [SW-1:0]   sa_gnt = '0;
  logic [NOVC-1:0] ovc_rsv = '0;
  logic fault_now, inval, xbar_discard, fault_latched;
  logic [VW-1:0] kill_va;
  logic [SW-1:0] kill_sa;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vc_alloc_guard #(.NPORT(NPORT), .NVC(NVC)) i_vc_alloc_guard (
    .clk(clk), .rst_n(rst_n), .va_gnt(va_gnt), .sa_gnt(sa_gnt),
    .ovc_rsv(ovc_rsv), .recov_done(recov_done), .fault_now(fault_now),
    .inval(inval), .kill_va(kill_va), .kill_sa(kill_sa),
    .xbar_discard(xbar_discard), .fault_latched(fault_latched));

  task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic vg(int ivc, int ovc);
    va_gnt[ivc*GW + ovc] = 1'b1;
  endtask

  task automatic sg(int ip, int op);
    sa_gnt[ip*NPORT + op] = 1'b1;
  endtask

  task automatic idle_clear();
    @(negedge clk);
    va_gnt = '0; sa_gnt = '0; ovc_rsv = '0; recov_done = 1;
    @(negedge clk);
    recov_done = 0;
  endtask

  // drive the current pattern for one cycle and check both stages
  task automatic run_case(string req, bit exp_fault);
    logic [VW-1:0] v;
    logic [SW-1:0] s;
    v = va_gnt; s = sa_gnt;
    #1;
    chk({req, " comb fault (R1)"}, VW'(fault_now), VW'(exp_fault));
    @(negedge clk);
    va_gnt = '0; sa_gnt = '0; ovc_rsv = '0;
    chk({req, " inval (R7)"}, VW'(inval), VW'(exp_fault));
    chk({req, " kill_va (R7)"}, kill_va, exp_fault ? v : '0);
    chk({req, " kill_sa (R7)"}, VW'(kill_sa), exp_fault ? VW'(s) : '0);
    chk({req, " discard (R8)"}, VW'(xbar_discard), VW'(exp_fault));
    chk({req, " latched (R9)"}, VW'(fault_latched), VW'(exp_fault));
    #1;
    chk({req, " comb clean (R1)"}, VW'(fault_now), '0);
    @(negedge clk);
    chk({req, " inval one cycle (R7)"}, VW'(inval), '0);
    chk({req, " discard one cycle (R8)"}, VW'(xbar_discard), '0);
    idle_clear();
  endtask

  task automatic t_reset();
    chk("R10 inval", VW'(inval), '0);
    chk("R10 kill_va", kill_va, '0);
    chk("R10 discard", VW'(xbar_discard), '0);
    chk("R10 latched", VW'(fault_latched), '0);
  endtask

  task automatic t_legal();
    @(negedge clk);
    vg(0, 9); vg(4, 0); vg(7, 3);
    ovc_rsv[5] = 1; ovc_rsv[6] = 1;
    sg(0, 2); sg(1, 3); sg(4, 0);
    run_case("R6 legal", 0);
  endtask

  task automatic t_va_dup();
    @(negedge clk);
    vg(1, 5); vg(6, 5); sg(2, 1);
    run_case("R2 dup vc", 1);
  endtask

  task automatic t_reserved();
    @(negedge clk);
    ovc_rsv[2] = 1; vg(3, 2);
    run_case("R3 reserved", 1);
  endtask

  task automatic t_badidx();
    @(negedge clk);
    vg(2, 12);
    run_case("R4 bad index", 1);
    @(negedge clk);
    vg(9, 15);
    run_case("R4 top index", 1);
  endtask

  task automatic t_multi_va();
    @(negedge clk);
    vg(0, 1); vg(0, 4);
    run_case("R4 multi-hot", 1);
  endtask

  task automatic t_sa();
    @(negedge clk);
    sg(0, 1); sg(3, 1);
    run_case("R5 sa dup", 1);
    @(negedge clk);
    sg(2, 0); sg(2, 4);
    run_case("R5 sa multi", 1);
  endtask

  task automatic t_sticky();
    @(negedge clk);
    vg(1, 5); vg(6, 5);
    @(negedge clk);
    va_gnt = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 held", VW'(fault_latched), 1);
    vg(1, 5); vg(6, 5); recov_done = 1;
    @(negedge clk);
    chk("R9 set beats clear", VW'(fault_latched), 1);
    va_gnt = '0;
    @(negedge clk);
    chk("R9 cleared", VW'(fault_latched), 0);
    recov_done = 0;
    @(negedge clk);
    chk("R9 stays clear", VW'(fault_latched), 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_legal();
    t_va_dup();
    t_reserved();
    t_badidx();
    t_multi_va();
    t_sa();
    t_sticky();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule